// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small controller-style system into and out of one of four sleep modes. When the CPU pulses its sleep request, the block samples a 2-bit mode selector. From that sample it decides which clocks to stop, whether to switch the main regulator off, and which wakeup sources may end the sleep. The three sources are an internal interrupt, an external interrupt and a periodic auto-wakeup tick. The asynchronous reset overrides everything.

A mode that keeps the regulator on resumes the clocks on the edge that sees a valid wakeup source. A mode that switched the regulator off first powers the regulator back up. It then holds the clocks off for a parameterised settle interval, and signals a pending wakeup while it waits. When the clocks return, a one-cycle strobe marks the event, together with a held code naming the source that ended the sleep.

Top module: `lp_seq`

## Requirements
- R1: While rst_ni is low, and right after it is released, cpu_clk_en_o, per_clk_en_o and reg_en_o are 1, and wake_o, wake_pend_o and wake_src_o are 0. This takes effect asynchronously, even in the middle of a settle interval.
- R2: In the run state, a sleep_req_i seen at a rising edge samples mode_i (00 wait, 01 active-halt with the regulator on, 10 active-halt with the regulator off, 11 halt) and enters sleep. Any change of mode_i during sleep, and any sleep_req_i outside the run state, has no effect.
- R3: In wait (00), only cpu_clk_en_o is 0. The internal or the external interrupt wakes the block; the auto-wakeup tick does not.
- R4: In active-halt with the regulator on (01), cpu_clk_en_o and per_clk_en_o are 0 and reg_en_o stays 1. The tick or the external interrupt wakes the block; the internal interrupt does not.
- R5: In active-halt with the regulator off (10), all three enables are 0. The tick or the external interrupt wakes the block.
- R6: In halt (11), all three enables are 0. Only the external interrupt wakes the block; the tick and the internal interrupt are ignored.
- R7: In a regulator-on mode, a valid source seen at a rising edge sets all enables to 1 right after that edge.
- R8: In a regulator-off mode, a valid source seen at a rising edge sets reg_en_o and wake_pend_o right after that edge, with the clocks still off. The clocks turn on, and wake_pend_o clears, exactly SETTLE_CYC edges later. A clock enable is never 1 while reg_en_o is 0.
- R9: wake_o is 1 for exactly the one cycle in which the clocks first return. wake_src_o takes the code of the waking source (01 internal, 10 external, 11 tick) when that source is seen, and holds it until the next wakeup.
- R10: When several valid sources arrive at the same edge, the code is chosen by priority: external, then internal, then tick.
- R11: A source that is not valid for the current mode has no effect. It leaves the enables, wake_o and wake_src_o unchanged, as does any source that arrives in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Sleep mode selector |
| sleep_req_i | input | 1 | Sleep request strobe from the CPU |
| int_irq_i | input | 1 | Internal interrupt wakeup source |
| ext_irq_i | input | 1 | External interrupt wakeup source |
| awu_tick_i | input | 1 | Periodic auto-wakeup tick |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| reg_en_o | output | 1 | Main regulator enable |
| wake_pend_o | output | 1 | Wakeup accepted, regulator settling |
| wake_o | output | 1 | One-cycle resume strobe |
| wake_src_o | output | 2 | Code of the source that ended the last sleep |

## Verification
Several things can happen at the same rising edge. A sleep request can arrive together with an interrupt. Two valid sources can arrive together. A valid source can arrive together with one the current mode does not accept. A reset can fall during a settle interval.

The bench drives each of these cases within a single cycle. It then judges the result at the ports. The interrupt seen in the run state must not cancel the entry into sleep. Simultaneous sources must yield the higher-priority code. An invalid companion must neither block nor relabel the wakeup. A reset in mid-settle must restore every enable before the next edge.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT   = 2'b00,
    MODE_AH_ON  = 2'b01,
    MODE_AH_OFF = 2'b10,
    MODE_HALT   = 2'b11
  } lp_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_INT  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_AWU  = 2'b11
  } wake_src_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_SLEEP  = 2'b01,
    ST_SETTLE = 2'b10
  } lp_state_e;

  typedef struct packed {
    logic per_off;
    logic reg_off;
    logic ok_ext;
    logic ok_int;
    logic ok_awu;
  } lp_policy_t;
endpackage

// File: rtl/lp_mode_decode.sv
module lp_mode_decode
  import lp_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  output lp_policy_t pol_o
);
  always_comb begin
    unique case (lp_mode_e'(mode_i))
      MODE_WAIT:   pol_o = '{per_off: 1'b0, reg_off: 1'b0, ok_ext: 1'b1, ok_int: 1'b1, ok_awu: 1'b0};
      MODE_AH_ON:  pol_o = '{per_off: 1'b1, reg_off: 1'b0, ok_ext: 1'b1, ok_int: 1'b0, ok_awu: 1'b1};
      MODE_AH_OFF: pol_o = '{per_off: 1'b1, reg_off: 1'b1, ok_ext: 1'b1, ok_int: 1'b0, ok_awu: 1'b1};
      default:     pol_o = '{per_off: 1'b1, reg_off: 1'b1, ok_ext: 1'b1, ok_int: 1'b0, ok_awu: 1'b0};
    endcase
  end
endmodule

// File: rtl/lp_wake_filter.sv
module lp_wake_filter
  import lp_seq_pkg::*;
(
  input  lp_policy_t pol_i,
  input  logic       int_irq_i,
  input  logic       ext_irq_i,
  input  logic       awu_tick_i,
  output logic       hit_o,
  output wake_src_e  src_o
);
  logic v_ext, v_int, v_awu;

  assign v_ext = ext_irq_i  & pol_i.ok_ext;
  assign v_int = int_irq_i  & pol_i.ok_int;
  assign v_awu = awu_tick_i & pol_i.ok_awu;
  assign hit_o = v_ext | v_int | v_awu;

  // fixed priority: external, internal, tick
  always_comb begin
    if (v_ext)      src_o = SRC_EXT;
    else if (v_int) src_o = SRC_INT;
    else if (v_awu) src_o = SRC_AWU;
    else            src_o = SRC_NONE;
  end
endmodule

// File: rtl/lp_settle_timer.sv
module lp_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sleep_req_i,
  input  logic       int_irq_i,
  input  logic       ext_irq_i,
  input  logic       awu_tick_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       reg_en_o,
  output logic       wake_pend_o,
  output logic       wake_o,
  output logic [1:0] wake_src_o
);
  lp_state_e  state_q, state_d;
  lp_policy_t pol_dec, pol_q;
  logic       hit;
  wake_src_e  hit_src, src_q;
  logic       settle_done, wake_q;

  lp_mode_decode u_dec (
    .mode_i (mode_i),
    .pol_o  (pol_dec)
  );

  lp_wake_filter u_filt (
    .pol_i      (pol_q),
    .int_irq_i  (int_irq_i),
    .ext_irq_i  (ext_irq_i),
    .awu_tick_i (awu_tick_i),
    .hit_o      (hit),
    .src_o      (hit_src)
  );

  lp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_SLEEP),
    .run_i   (state_q == ST_SETTLE),
    .done_o  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (sleep_req_i) state_d = ST_SLEEP;
      ST_SLEEP:  if (hit) state_d = pol_q.reg_off ? ST_SETTLE : ST_RUN;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pol_q   <= '0;
      src_q   <= SRC_NONE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q != ST_RUN) && (state_d == ST_RUN);
      if (state_q == ST_RUN && sleep_req_i) pol_q <= pol_dec;
      if (state_q == ST_SLEEP && hit)       src_q <= hit_src;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = ~pol_q.per_off;
        reg_en_o     = ~pol_q.reg_off;
      end
      ST_SETTLE: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        reg_en_o     = 1'b1;
      end
      default: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        reg_en_o     = 1'b1;
      end
    endcase
  end

  assign wake_pend_o = (state_q == ST_SETTLE);
  assign wake_o      = wake_q;
  assign wake_src_o  = src_q;
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       sleep_req_i,
  input logic       int_irq_i,
  input logic       ext_irq_i,
  input logic       awu_tick_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       reg_en_o,
  input logic       wake_pend_o,
  input logic       wake_o,
  input logic [1:0] wake_src_o
);
  p_clk_needs_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o || per_clk_en_o) |-> reg_en_o);

  p_reg_before_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> !cpu_clk_en_o);

  p_pend_clocks_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pend_o |-> (reg_en_o && !cpu_clk_en_o && !per_clk_en_o));

  p_wake_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_wake_on_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> wake_o);

  p_wake_needs_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cpu_clk_en_o && per_clk_en_o && !wake_pend_o));
endmodule

bind lp_seq lp_seq_chk u_chk (.*);

// File: tb/lp_seq_test.sv
module lp_seq_test;
  localparam int unsigned SETTLE_CYC = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       sleep_req_i = 1'b0;
  logic       int_irq_i = 1'b0;
  logic       ext_irq_i = 1'b0;
  logic       awu_tick_i = 1'b0;
  logic       cpu_clk_en_o, per_clk_en_o, reg_en_o, wake_pend_o, wake_o;
  logic [1:0] wake_src_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] last_code = 2'b00;

  always #4 clk_i = ~clk_i;

  lp_seq #(.SETTLE_CYC(SETTLE_CYC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .sleep_req_i(sleep_req_i),
    .int_irq_i(int_irq_i), .ext_irq_i(ext_irq_i), .awu_tick_i(awu_tick_i),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o), .reg_en_o(reg_en_o),
    .wake_pend_o(wake_pend_o), .wake_o(wake_o), .wake_src_o(wake_src_o)
  );

  // {mode, ext, int, awu, expect_wake, code}
  localparam logic [7:0] VEC [12] = '{
    {2'b00, 3'b010, 1'b1, 2'b01},  // R3 internal wakes wait
    {2'b00, 3'b100, 1'b1, 2'b10},  // R3 external wakes wait
    {2'b00, 3'b001, 1'b0, 2'b00},  // R3 tick ignored in wait
    {2'b00, 3'b110, 1'b1, 2'b10},  // R10 external over internal
    {2'b01, 3'b001, 1'b1, 2'b11},  // R4 tick wakes
    {2'b01, 3'b010, 1'b0, 2'b00},  // R4 internal ignored
    {2'b01, 3'b011, 1'b1, 2'b11},  // R11 invalid companion
    {2'b10, 3'b001, 1'b1, 2'b11},  // R5 tick wakes, settle
    {2'b10, 3'b101, 1'b1, 2'b10},  // R10 external over tick
    {2'b11, 3'b001, 1'b0, 2'b00},  // R6 tick ignored in halt
    {2'b11, 3'b010, 1'b0, 2'b00},  // R6 internal ignored in halt
    {2'b11, 3'b100, 1'b1, 2'b10}   // R6 external wakes halt
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_en(string req, logic c, logic p, logic r);
    chk(req, "enables {cpu,per,reg}", {5'd0, cpu_clk_en_o, per_clk_en_o, reg_en_o}, {5'd0, c, p, r});
  endtask

  task automatic enter_sleep(logic [1:0] m);
    mode_i = m;
    sleep_req_i = 1'b1;
    tick();
    sleep_req_i = 1'b0;
    mode_i = ~m;  // R2: must not matter during sleep
    chk_en("R2", 1'b0, (m == 2'b00), ~m[1]);
  endtask

  // source has been sampled at the last edge
  task automatic expect_resume(logic regoff, logic [1:0] code);
    if (regoff) begin
      chk_en("R8", 1'b0, 1'b0, 1'b1);
      chk("R8", "pending", {7'd0, wake_pend_o}, 8'd1);
      for (int k = 1; k < SETTLE_CYC; k++) begin
        tick();
        chk("R8", "cpu clock held off", {7'd0, cpu_clk_en_o}, 8'd0);
      end
      tick();
      chk("R8", "pending cleared", {7'd0, wake_pend_o}, 8'd0);
    end
    chk_en(regoff ? "R8" : "R7", 1'b1, 1'b1, 1'b1);
    chk("R9", "wake strobe", {7'd0, wake_o}, 8'd1);
    chk("R9", "wake code", {6'd0, wake_src_o}, {6'd0, code});
    last_code = code;
    tick();
    chk("R9", "strobe one cycle", {7'd0, wake_o}, 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk_en("R1", 1'b1, 1'b1, 1'b1);
    chk("R1", "flags in reset", {4'd0, wake_pend_o, wake_o, wake_src_o}, 8'd0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk_en("R1", 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = VEC[i];
      enter_sleep(v[7:6]);
      {ext_irq_i, int_irq_i, awu_tick_i} = v[5:3];
      tick();
      {ext_irq_i, int_irq_i, awu_tick_i} = 3'b000;
      if (v[2]) begin
        expect_resume(v[7], v[1:0]);
      end else begin
        chk_en("R11", 1'b0, (v[7:6] == 2'b00), ~v[7]);
        chk("R11", "no strobe, code held", {5'd0, wake_o, wake_src_o}, {6'd0, last_code});
        ext_irq_i = 1'b1;
        tick();
        ext_irq_i = 1'b0;
        expect_resume(v[7], 2'b10);
      end
    end

    // R2/R11: interrupt in the same cycle as the sleep request
    mode_i = 2'b01;
    sleep_req_i = 1'b1;
    ext_irq_i = 1'b1;
    tick();
    sleep_req_i = 1'b0;
    ext_irq_i = 1'b0;
    chk_en("R11", 1'b0, 1'b0, 1'b1);
    chk("R11", "run-state source ignored", {7'd0, wake_o}, 8'd0);
    // R2: new request while asleep is ignored
    mode_i = 2'b00;
    sleep_req_i = 1'b1;
    tick();
    sleep_req_i = 1'b0;
    chk_en("R2", 1'b0, 1'b0, 1'b1);
    awu_tick_i = 1'b1;
    tick();
    awu_tick_i = 1'b0;
    expect_resume(1'b0, 2'b11);

    // R1: reset in the middle of a settle interval
    enter_sleep(2'b10);
    awu_tick_i = 1'b1;
    tick();
    awu_tick_i = 1'b0;
    tick();
    chk("R8", "mid-settle pending", {7'd0, wake_pend_o}, 8'd1);
    rst_ni = 1'b0;
    #1;
    chk_en("R1", 1'b1, 1'b1, 1'b1);
    chk("R1", "flags after reset", {4'd0, wake_pend_o, wake_o, wake_src_o}, 8'd0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk_en("R1", 1'b1, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule